// File: doc/BRIEF.md
# Prescaled 16-bit Reference Timer Pair

This block holds two 16-bit up-counters. Each counter advances on a count tick that is built from a chosen source. The source is the system clock, the system clock divided by sixteen, or, for the second timer only, the reference matches of the first timer. A primary divider and a secondary divider, both eight bits wide, then slow the source down. When a tick arrives while the counter equals its reference value, the timer latches a reference event. It then either returns to zero or keeps counting. The latched event can drive a level interrupt.

Software reaches the block over a simple synchronous register port with single-cycle writes and combinational reads. A single shared control byte packs the release and stop bits of both timers. Software can therefore start, stop or hold both timers together in one write, or handle each one on its own.

Top module: `tmr_pair`

## Requirements
- R1: After the asynchronous reset every register reads zero, both interrupts are low and both timers are held. Address bit 3 selects the timer. Address bits [2:0] select the register: 0 is the shared control byte (timer-0 half only), 1 is mode, 2 is reference, 3 is counter, 4 is event and 5 is the primary prescale register. Every other location reads zero.
- R2: In the control byte, bit 0 releases timer 0 and bit 1 stops it. Bit 4 releases timer 1 and bit 5 stops it. A timer counts only when it is released and not stopped, and the two timers are controlled independently.
- R3: Mode bits [2:1] choose the tick source. Value 1 is every clock, value 2 is every sixteenth clock, and value 0 is cascade, which only timer 1 supports. Value 3, and value 0 on timer 0, give no ticks.
- R4: The secondary prescale sps is mode bits [15:8]. The primary prescale psr is bits [7:0] of the prescale register. Once a timer is released from hold, its counter advances once every base·(psr+1)·(sps+1) running cycles, where base is 1 or 16.
- R5: A tick that arrives while the counter equals the reference sets event bit 1. If mode bit 3 is set, the counter returns to zero on that tick. Otherwise it increments and wraps from 0xFFFF to 0.
- R6: The interrupt of a timer equals event bit 1 AND mode bit 4, and it is held as a level.
- R7: Writing the event register clears each event bit written as 1 and leaves the others unchanged. A match in the same cycle wins over a clear. Event bits other than bit 1 read zero.
- R8: A write to the counter register loads the written value.
- R9: A stopped, released timer keeps its counter and its prescaler phase.
- R10: A held timer reads counter zero and event zero, and ignores counter writes.
- R11: In cascade mode, timer 1 advances exactly once for each reference match of timer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 2 | Per-timer level interrupt |

## Verification
A table of settings is run on timer 0 for a fixed number of cycles. It covers every source, unit and non-unit primary and secondary prescale values, reference zero, and free-running versus restart mode. Each window is chosen so that it ends just short of, or just past, a reference match. This separates an off-by-one in the division ratio from an error in the match or restart logic. Directed sequences then cover stopping and resuming, counter loads that wrap past 0xFFFF, hold, write-one-to-clear with zero and inverted masks, a masked interrupt, cascading, and one timer running while the other is stopped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_CNT_W  = 16;
  localparam int TMR_PS_W   = 8;
  localparam int TMR_SLOWDV = 16;

  typedef enum logic [1:0] {
    SRC_CASCADE = 2'd0,
    SRC_SYS     = 2'd1,
    SRC_SLOW    = 2'd2,
    SRC_NONE    = 2'd3
  } clk_src_e;

  // Counter value after a tick: restart on a match in restart mode.
  function automatic logic [TMR_CNT_W-1:0] next_count(
    input logic [TMR_CNT_W-1:0] cur,
    input logic                 hit,
    input logic                 restart
  );
    if (hit && restart) return '0;
    return cur + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int   PS_W     = tmr_pkg::TMR_PS_W,
  parameter int   SLOW_DIV = tmr_pkg::TMR_SLOWDV,
  parameter logic CASC_OK  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [1:0]      sel,
  input  logic [PS_W-1:0] psr,
  input  logic [PS_W-1:0] sps,
  input  logic            casc_in,
  output logic            tick
);
  import tmr_pkg::*;
  localparam int SLOW_W = $clog2(SLOW_DIV);

  logic [SLOW_W-1:0] slow_q;
  logic [PS_W-1:0]   p1_q, p2_q;
  logic              slow_wrap, base_en, p1_en;

  assign slow_wrap = (slow_q == SLOW_W'(SLOW_DIV - 1));

  always_comb begin
    case (clk_src_e'(sel))
      SRC_SYS:     base_en = run;
      SRC_SLOW:    base_en = run & slow_wrap;
      SRC_CASCADE: base_en = run & CASC_OK & casc_in;
      default:     base_en = 1'b0;
    endcase
  end

  assign p1_en = base_en & (p1_q >= psr);
  assign tick  = p1_en & (p2_q >= sps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else if (clr) begin
      slow_q <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else begin
      if (run)     slow_q <= slow_wrap ? '0 : slow_q + 1'b1;
      if (base_en) p1_q   <= p1_en ? '0 : p1_q + 1'b1;
      if (p1_en)   p2_q   <= tick ? '0 : p2_q + 1'b1;
    end
  end

  assert_phase_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(p1_q) && $stable(p2_q) && $stable(slow_q)));

  assert_phase_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (p1_q == '0 && p2_q == '0 && slow_q == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = tmr_pkg::TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             held,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             evt_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_ref,
  output logic             match
);
  import tmr_pkg::*;

  assign match = tick & (cnt == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      evt_ref <= 1'b0;
    end else if (held) begin
      cnt     <= '0;
      evt_ref <= 1'b0;
    end else begin
      if (cnt_wr)    cnt <= cnt_wdata;
      else if (tick) cnt <= next_count(cnt, match, restart);
      if (match)        evt_ref <= 1'b1;
      else if (evt_clr) evt_ref <= 1'b0;
    end
  end

  assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !tick && !cnt_wr) |=> $stable(cnt));

  assert_held_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (cnt == '0 && !evt_ref));

  assert_match_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !held) |=> evt_ref);

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && restart && !held && !cnt_wr) |=> (cnt == '0));

  assert_event_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ref && !held && !evt_clr) |=> evt_ref);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int CNT_W    = tmr_pkg::TMR_CNT_W,
  parameter int PS_W     = tmr_pkg::TMR_PS_W,
  parameter int SLOW_DIV = tmr_pkg::TMR_SLOWDV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [1:0]       irq
);
  localparam int NTMR      = 2;
  localparam int CFG_W     = 8;
  localparam int CFG_STEP  = CFG_W / NTMR;
  localparam int SPS_LSB   = CNT_W - PS_W;
  localparam logic [2:0] A_CFG = 3'd0, A_MODE = 3'd1, A_REF = 3'd2,
                         A_CNT = 3'd3, A_EVT = 3'd4, A_PSR = 3'd5;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] mode_q [NTMR];
  logic [CNT_W-1:0] ref_q  [NTMR];
  logic [PS_W-1:0]  psr_q  [NTMR];
  logic [CNT_W-1:0] cnt    [NTMR];
  logic [NTMR-1:0]  evt_ref, match, tick, held, run;

  logic       sel_t;
  logic [2:0] reg_a;
  assign sel_t = bus_addr[3];
  assign reg_a = bus_addr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (bus_wr && !sel_t && reg_a == A_CFG) cfg_q <= bus_wdata[CFG_W-1:0];
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    logic sel_me;
    assign sel_me  = bus_wr && (sel_t == t[0]);
    assign held[t] = ~cfg_q[t*CFG_STEP];
    assign run[t]  = ~held[t] & ~cfg_q[t*CFG_STEP + 1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[t] <= '0;
        ref_q[t]  <= '0;
        psr_q[t]  <= '0;
      end else if (sel_me) begin
        if (reg_a == A_MODE) mode_q[t] <= bus_wdata;
        if (reg_a == A_REF)  ref_q[t]  <= bus_wdata;
        if (reg_a == A_PSR)  psr_q[t]  <= bus_wdata[PS_W-1:0];
      end
    end

    tmr_prescale #(
      .PS_W(PS_W), .SLOW_DIV(SLOW_DIV), .CASC_OK(t != 0)
    ) u_ps (
      .clk(clk), .rst_n(rst_n), .clr(held[t]), .run(run[t]),
      .sel(mode_q[t][2:1]), .psr(psr_q[t]),
      .sps(mode_q[t][SPS_LSB +: PS_W]),
      .casc_in((t == 0) ? 1'b0 : match[0]),
      .tick(tick[t])
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .held(held[t]), .tick(tick[t]),
      .restart(mode_q[t][3]), .ref_val(ref_q[t]),
      .cnt_wr(sel_me && reg_a == A_CNT), .cnt_wdata(bus_wdata),
      .evt_clr(sel_me && reg_a == A_EVT && bus_wdata[1]),
      .cnt(cnt[t]), .evt_ref(evt_ref[t]), .match(match[t])
    );

    assign irq[t] = evt_ref[t] & mode_q[t][4];
  end

  always_comb begin
    case (reg_a)
      A_CFG:   bus_rdata = sel_t ? '0 : CNT_W'(cfg_q);
      A_MODE:  bus_rdata = mode_q[sel_t];
      A_REF:   bus_rdata = ref_q[sel_t];
      A_CNT:   bus_rdata = cnt[sel_t];
      A_EVT:   bus_rdata = CNT_W'({evt_ref[sel_t], 1'b0});
      A_PSR:   bus_rdata = CNT_W'(psr_q[sel_t]);
      default: bus_rdata = '0;
    endcase
  end

  assert_cascade_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1][2:1] == 2'd0 && mode_q[1][SPS_LSB +: PS_W] == '0 && psr_q[1] == '0
     && run[1]) |-> (tick[1] == match[0]));

  assert_stopped_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] || !run[1]) |-> ($countones(tick & ~run) == 0));
endmodule

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  psr;
    logic [7:0]  sps;
    logic [15:0] refv;
    logic        frr;
    logic [15:0] w;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd0, 8'd0, 16'd5,   1'b1, 16'd4},
    '{2'd1, 8'd0, 8'd0, 16'd5,   1'b1, 16'd9},
    '{2'd1, 8'd0, 8'd0, 16'd5,   1'b0, 16'd9},
    '{2'd1, 8'd2, 8'd1, 16'd100, 1'b0, 16'd20},
    '{2'd2, 8'd0, 8'd0, 16'd3,   1'b1, 16'd70},
    '{2'd2, 8'd1, 8'd2, 16'd0,   1'b0, 16'd200},
    '{2'd3, 8'd0, 8'd0, 16'd0,   1'b0, 16'd10},
    '{2'd0, 8'd0, 8'd0, 16'd0,   1'b0, 16'd10}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Run with control value 'go' for exactly w clock edges, then write 'halt'.
  task automatic run_for(logic [7:0] go, logic [7:0] halt, int w);
    wr(4'd0, {8'd0, go});
    repeat (w - 2) @(negedge clk);
    wr(4'd0, {8'd0, halt});
  endtask

  function automatic logic [15:0] mode_word(logic [7:0] sps, logic ori,
                                            logic frr, logic [1:0] sel);
    return {sps, 3'b000, ori, frr, sel, 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(4'd0, r);  check("R1 cfg", r, 16'h0000);
    rd(4'd1, r);  check("R1 mode0", r, 16'h0000);
    rd(4'd11, r); check("R1 cnt1", r, 16'h0000);
    rd(4'd7, r);  check("R1 unused addr", r, 16'h0000);
    check("R1 irq", {14'd0, irq}, 16'h0000);

    // Vector table on timer 0: R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      int d, t;
      logic [15:0] ecnt;
      logic ev;
      d = ((VECS[i].sel == 2'd2) ? 16 : 1) * (VECS[i].psr + 1) * (VECS[i].sps + 1);
      t = (VECS[i].sel == 2'd1 || VECS[i].sel == 2'd2) ? (VECS[i].w / d) : 0;
      ev = (t >= VECS[i].refv + 1);
      ecnt = VECS[i].frr ? 16'(t % (VECS[i].refv + 1)) : 16'(t);
      wr(4'd0, 16'h0000);
      wr(4'd1, mode_word(VECS[i].sps, 1'b1, VECS[i].frr, VECS[i].sel));
      wr(4'd5, {8'd0, VECS[i].psr});
      wr(4'd2, VECS[i].refv);
      run_for(8'h01, 8'h03, VECS[i].w);
      rd(4'd3, r); check($sformatf("R4 R3 vec%0d count", i), r, ecnt);
      rd(4'd4, r); check($sformatf("R5 vec%0d event", i), r, {14'd0, ev, 1'b0});
      check($sformatf("R6 vec%0d irq", i), {15'd0, irq[0]}, {15'd0, ev});
    end

    // R9: stop holds count, resume continues
    wr(4'd0, 16'h0000);
    wr(4'd1, mode_word(8'd0, 1'b1, 1'b0, 2'd1));
    wr(4'd5, 16'h0000);
    wr(4'd2, 16'd1000);
    run_for(8'h01, 8'h03, 5);
    rd(4'd3, r); check("R9 before hold", r, 16'd5);
    repeat (10) @(negedge clk);
    rd(4'd3, r); check("R9 stopped holds", r, 16'd5);
    run_for(8'h01, 8'h03, 2);
    rd(4'd3, r); check("R9 resume", r, 16'd7);

    // R8 load and R5 wrap past 0xFFFF
    wr(4'd3, 16'hFFFE);
    rd(4'd3, r); check("R8 load", r, 16'hFFFE);
    run_for(8'h01, 8'h03, 3);
    rd(4'd3, r); check("R5 wrap", r, 16'h0001);

    // R10: hold zeroes and ignores writes
    wr(4'd0, 16'h0002);
    rd(4'd3, r); check("R10 held zero", r, 16'h0000);
    wr(4'd3, 16'h1234);
    rd(4'd3, r); check("R10 write ignored", r, 16'h0000);

    // R7 / R6: write-one-to-clear
    wr(4'd0, 16'h0000);
    wr(4'd1, mode_word(8'd0, 1'b1, 1'b1, 2'd1));
    wr(4'd2, 16'd2);
    run_for(8'h01, 8'h03, 3);
    rd(4'd4, r); check("R5 event at third tick", r, 16'h0002);
    check("R6 irq raised", {15'd0, irq[0]}, 16'd1);
    wr(4'd4, 16'h0000);
    rd(4'd4, r); check("R7 zero mask keeps", r, 16'h0002);
    wr(4'd4, 16'hFFFD);
    rd(4'd4, r); check("R7 other bits keep", r, 16'h0002);
    wr(4'd4, 16'h0002);
    rd(4'd4, r); check("R7 cleared", r, 16'h0000);
    check("R6 irq dropped", {15'd0, irq[0]}, 16'd0);

    // R6: masked interrupt
    wr(4'd0, 16'h0000);
    wr(4'd1, mode_word(8'd0, 1'b0, 1'b1, 2'd1));
    run_for(8'h01, 8'h03, 3);
    rd(4'd4, r); check("R6 event without enable", r, 16'h0002);
    check("R6 irq masked", {15'd0, irq[0]}, 16'd0);

    // R11: cascade, both timers started in one write (R2)
    wr(4'd0, 16'h0000);
    wr(4'd1, mode_word(8'd0, 1'b0, 1'b1, 2'd1));
    wr(4'd2, 16'd2);
    wr(4'd9, mode_word(8'd0, 1'b0, 1'b0, 2'd0));
    wr(4'd10, 16'hFFFF);
    wr(4'd13, 16'h0000);
    run_for(8'h11, 8'h33, 10);
    rd(4'd11, r); check("R11 cascade count", r, 16'd3);
    rd(4'd3, r);  check("R11 source count", r, 16'd1);

    // R2: timer 1 runs alone while timer 0 is stopped
    wr(4'd9, mode_word(8'd0, 1'b0, 1'b0, 2'd1));
    run_for(8'h13, 8'h33, 5);
    rd(4'd11, r); check("R2 timer1 alone", r, 16'd8);
    rd(4'd3, r);  check("R2 timer0 kept", r, 16'd1);
    rd(4'd0, r);  check("R2 cfg readback", r, 16'h0033);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule